// File: doc/BRIEF.md
# Dual-Priority Interrupt Request Controller

This block gathers six interrupt sources and steers them onto two active-low CPU interrupt lines: a normal request line and a fast request line. Three sources are active-low external pins: cartridge, keyboard and serial input. Their requests are level based, so a pin is active for as long as it is held low. The other three are single-cycle internal strobes: vertical border, horizontal border and timer. Each strobe sets a flag that stays set until software reads it back.

Each output line has its own byte-wide enable register, and both registers use the same bit layout. A master enable bit, which comes from the neighbouring initialization register, gates each line. A read of an enable register does not return the stored mask. It returns the live requests that this register enables. A source that is enabled in both registers shows up in both reads. A read also clears the edge flags that it reports.

The master bits are inputs from the block that owns the initialization register (bit 5 there for the normal line, bit 4 for the fast line). The CPU reaches the two enable registers through a chip-select, read and write strobe bus with a one-bit register select.

Top module: `irq_pair_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, both enable registers and all edge flags are zero, `irq_n` and `firq_n` are high, and `rdata` is zero.
- R2: The status bit positions are: bit 0 cartridge, bit 1 keyboard, bit 2 serial, bit 3 vertical border, bit 4 horizontal border, bit 5 timer. Bits 6 and 7 always read zero, even after 1s are written to them.
- R3: When `cs` and `wr` are high at a clock edge, `wdata` is stored in the normal enable register if `addr`=0, or in the fast enable register if `addr`=1. The other register is left unchanged.
- R4: When `cs` and `rd` are high at a clock edge, `rdata` takes the value (status AND selected enable) at that edge, and then holds it until the next read.
- R5: An external pin counts as active once it has been low for `SYNC_STAGES` clock edges. Its status bit clears again when the pin returns high; it is never latched.
- R6: A border or timer strobe sets its flag. The flag stays set until a read of a register whose enable bit for that source is 1, and that read clears it.
- R7: If a strobe arrives in the same cycle as a read that clears its flag, the flag stays set. The read still reports the source.
- R8: `irq_n` goes low on the edge after (status AND normal enable) becomes nonzero while `irq_master` is 1. It stays high whenever `irq_master` was 0 at the previous edge. `firq_n` behaves the same way with the fast enable and `firq_master`.
- R9: A source enabled in both registers reads as set from either register, and it drives both lines.
- R10: A read of a register that does not enable a flagged source leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Register access select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | 0 = normal enable register, 1 = fast enable register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data (live enabled status) |
| irq_master | input | 1 | Master gate for the normal line (initialization register bit 5) |
| firq_master | input | 1 | Master gate for the fast line (initialization register bit 4) |
| cart_n | input | 1 | Cartridge request, active low |
| kbd_n | input | 1 | Keyboard request, active low |
| ser_n | input | 1 | Serial input request, active low |
| vbord_stb | input | 1 | Vertical border event strobe |
| hbord_stb | input | 1 | Horizontal border event strobe |
| tmr_stb | input | 1 | Timer zero-crossing strobe |
| irq_n | output | 1 | Normal interrupt line, active low |
| firq_n | output | 1 | Fast interrupt line, active low |

## Verification
Two functions can fall in the same clock edge: a new border event setting its flag, and a status read that would clear that same flag. The bench raises the horizontal border strobe and a read of the normal register together, on one edge, while the flag is already pending. It then expects that read to report bit 4, and a second read to report bit 4 again, because the new event must survive the clear. Only a third read may return zero. A second pairing is covered by flagging a source that is enabled in only one register, reading the register that does not enable it, and then expecting the flag to still be present in the other register.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_PIN  = 3;
  localparam int NUM_EVT  = NUM_SRC - NUM_PIN;
  // status bit positions (software decodes these)
  localparam int SRC_CART  = 0;
  localparam int SRC_KBD   = 1;
  localparam int SRC_SER   = 2;
  localparam int SRC_VBORD = 3;
  localparam int SRC_HBORD = 4;
  localparam int SRC_TMR   = 5;
  localparam int NUM_OUT   = 2;
  typedef enum logic {SEL_NORM = 1'b0, SEL_FAST = 1'b1} reg_sel_e;
endpackage

// File: rtl/irqr_pin_sync.sv
module irqr_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] active
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = ~pin_n;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign active = stage_q[STAGES-1];
endmodule

// File: rtl/irqr_event_flags.sv
module irqr_event_flags #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] stb,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flag
);
  logic [WIDTH-1:0] flag_q, flag_d;

  always_comb begin
    // a fresh event wins over a clear in the same cycle
    flag_d = (flag_q & ~clr) | stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_chk
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stb[g] |=> flag[g]);
      assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[g] && !clr[g]) |=> flag[g]);
    end
  endgenerate
endmodule

// File: rtl/irqr_out_drive.sv
module irqr_out_drive #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] enable,
  input  logic             master,
  output logic             line_n
);
  logic line_n_q, line_n_d;

  always_comb begin
    line_n_d = ~(master & (|(status & enable)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_n_q <= 1'b1;
    else        line_n_q <= line_n_d;
  end

  assign line_n = line_n_q;

  assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> line_n);
endmodule

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              irq_master,
  input  logic              firq_master,
  input  logic              cart_n,
  input  logic              kbd_n,
  input  logic              ser_n,
  input  logic              vbord_stb,
  input  logic              hbord_stb,
  input  logic              tmr_stb,
  output logic              irq_n,
  output logic              firq_n
);
  import irqr_pkg::*;

  localparam int PAD_W = DATA_W - NUM_SRC;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // level sources
  logic [NUM_PIN-1:0] pin_act;
  irqr_pin_sync #(.WIDTH(NUM_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_n  ({ser_n, kbd_n, cart_n}),
    .active (pin_act)
  );

  // edge sources
  logic [NUM_EVT-1:0] evt_flag, evt_clr;
  irqr_event_flags #(.WIDTH(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .stb   ({tmr_stb, hbord_stb, vbord_stb}),
    .clr   (evt_clr),
    .flag  (evt_flag)
  );

  logic [DATA_W-1:0] status;
  assign status = {{PAD_W{1'b0}}, evt_flag, pin_act};

  // enable registers
  logic [DATA_W-1:0] en_q [NUM_OUT];
  logic [DATA_W-1:0] en_d [NUM_OUT];
  logic              wr_fire, rd_fire;
  assign wr_fire = cs & wr;
  assign rd_fire = cs & rd;

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_en
      always_comb begin
        en_d[g] = en_q[g];
        if (wr_fire && (int'(addr) == g)) en_d[g] = wdata;
      end
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) en_q[g] <= '0;
        else            en_q[g] <= en_d[g];
      end
      assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
        !(wr_fire && (int'(addr) == g)) |=> $stable(en_q[g]));
    end
  endgenerate

  // read path
  logic [DATA_W-1:0] sel_en, rd_view, rdata_q, rdata_d;
  assign sel_en  = (reg_sel_e'(addr) == SEL_FAST) ? en_q[1] : en_q[0];
  assign rd_view = status & sel_en;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_fire) rdata_d = rd_view;
    evt_clr = rd_fire ? rd_view[NUM_PIN +: NUM_EVT] : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_fire |=> $stable(rdata));
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    rdata[DATA_W-1:NUM_SRC] == '0);

  // outputs
  irqr_out_drive #(.WIDTH(DATA_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .status (status),
    .enable (en_q[0]),
    .master (irq_master),
    .line_n (irq_n)
  );
  irqr_out_drive #(.WIDTH(DATA_W)) u_firq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .status (status),
    .enable (en_q[1]),
    .master (firq_master),
    .line_n (firq_n)
  );
endmodule

// File: tb/irq_pair_ctrl_bench.sv
module irq_pair_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_master = 0, firq_master = 0;
  logic cart_n = 1, kbd_n = 1, ser_n = 1;
  logic vbord_stb = 0, hbord_stb = 0, tmr_stb = 0;
  logic irq_n, firq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_pair_ctrl u_irq_pair_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_master(irq_master),
    .firq_master(firq_master), .cart_n(cart_n), .kbd_n(kbd_n), .ser_n(ser_n),
    .vbord_stb(vbord_stb), .hbord_stb(hbord_stb), .tmr_stb(tmr_stb),
    .irq_n(irq_n), .firq_n(firq_n)
  );

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 0;

  always @(posedge clk) rd_seen <= cs & rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s rdata actual=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic check_bit(input string t, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic read_reg(input logic a, input logic [7:0] e, input string t);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  // read issued on the same edge as a horizontal border strobe
  task automatic read_with_hbord(input logic a, input logic [7:0] e, input string t);
    @(negedge clk);
    cs = 1; rd = 1; addr = a; hbord_stb = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    cs = 0; rd = 0; hbord_stb = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      3: vbord_stb = 1;
      4: hbord_stb = 1;
      default: tmr_stb = 1;
    endcase
    @(negedge clk);
    vbord_stb = 0; hbord_stb = 0; tmr_stb = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: outputs during reset
    check_bit("R1 irq_n in reset", irq_n, 1'b1);
    check_bit("R1 firq_n in reset", firq_n, 1'b1);
    @(negedge clk); rst_n = 1;
    idle(4);
    check_bit("R1 irq_n after reset", irq_n, 1'b1);
    check_bit("R1 firq_n after reset", firq_n, 1'b1);
    total++;
    if (rdata !== 8'h00) begin bad++; $display("FAIL R1 rdata actual=%02h expected=00", rdata); end

    // R3 / R2: enable all bits of the normal register, upper bits read zero
    write_reg(1'b0, 8'hFF);
    irq_master = 1;
    read_reg(1'b0, 8'h00, "R4 idle status");

    // R5 keyboard level
    kbd_n = 0; idle(4);
    check_bit("R5 R8 irq_n with kbd low", irq_n, 1'b0);
    check_bit("R8 firq_n fast reg empty", firq_n, 1'b1);
    read_reg(1'b0, 8'h02, "R2 R5 kbd bit1");
    read_reg(1'b1, 8'h00, "R3 fast reg not written");
    kbd_n = 1; idle(4);
    check_bit("R5 irq_n after release", irq_n, 1'b1);
    read_reg(1'b0, 8'h00, "R5 no latching");

    // R8 master gate
    irq_master = 0; kbd_n = 0; idle(5);
    check_bit("R8 gated by master", irq_n, 1'b1);
    irq_master = 1; idle(2);
    check_bit("R8 master reopened", irq_n, 1'b0);
    kbd_n = 1; idle(4);

    // R6 timer flag
    pulse(5); idle(1);
    check_bit("R6 R8 irq_n on timer", irq_n, 1'b0);
    read_reg(1'b0, 8'h20, "R6 timer bit5");
    read_reg(1'b0, 8'h00, "R6 cleared by read");
    idle(1);
    check_bit("R6 irq_n after clear", irq_n, 1'b1);

    // R10 read of non-enabling register keeps flag
    pulse(3);
    read_reg(1'b1, 8'h00, "R10 fast reg hides vbord");
    read_reg(1'b0, 8'h08, "R10 vbord kept bit3");
    read_reg(1'b0, 8'h00, "R6 vbord cleared");

    // R9 both registers
    write_reg(1'b1, 8'h3F);
    firq_master = 1;
    ser_n = 0; idle(4);
    read_reg(1'b0, 8'h04, "R9 serial in normal");
    read_reg(1'b1, 8'h04, "R9 serial in fast");
    check_bit("R9 irq_n", irq_n, 1'b0);
    check_bit("R9 firq_n", firq_n, 1'b0);
    ser_n = 1; idle(4);
    check_bit("R9 firq_n released", firq_n, 1'b1);

    // R7 strobe and clearing read on the same edge
    pulse(4);
    read_with_hbord(1'b0, 8'h10, "R7 read with strobe");
    read_reg(1'b0, 8'h10, "R7 flag survived");
    read_reg(1'b0, 8'h00, "R7 then cleared");

    // R3 selective write, R2 cartridge bit0, R10 across registers
    write_reg(1'b0, 8'h01);
    cart_n = 0; idle(3);
    pulse(5);
    read_reg(1'b0, 8'h01, "R3 normal reg now 01");
    read_reg(1'b1, 8'h21, "R2 R10 timer kept for fast reg");
    read_reg(1'b1, 8'h01, "R6 timer cleared by fast read");
    cart_n = 1;
    idle(4);
    finish_run();
  end
endmodule